// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Stall Unit

This block sits next to the execute stage of a five-stage in-order pipeline. It finds read-after-write dependencies and picks where each of the two ALU operands comes from. Both source register indices of the instruction in execute are compared against the destination indices of the two older instructions still in flight. These are the instruction one slot ahead, now in the memory stage, and the instruction two slots ahead, now in write-back. Each operand then takes one of three sources: the register-file read value, the previous ALU result, or the result from two instructions back. A dependency three slots apart needs no select. The register file writes in the first half of a cycle and reads in the second half, so that read already returns the new value.

A loaded value exists only at the end of the memory stage. An instruction that reads a load's destination in the very next slot therefore cannot be served by forwarding. The block watches the instruction in decode against a load in execute and raises a stall request for exactly one cycle. During that cycle the PC and the fetch/decode register hold, and a bubble is placed into execute. After the bubble, the dependent instruction meets the load in write-back and takes the two-back path like any other operand.

The stall control is a two-state machine. In RUN a detected load-use hazard asserts the stall and bubble requests, and the transition RUN to HOLD is taken on the next edge. With no hazard the machine stays in RUN. In HOLD both requests are low whatever the inputs, and the transition HOLD to RUN is taken unconditionally. Reset enters RUN.

Top module: `fwd_hazard_unit`

## Requirements
- R1: When an operand's source index matches no qualifying older destination, its select is 2'b00 (register-file value).
- R2: When an operand's source index equals the memory-stage destination, and that stage's write enable is high, the select is 2'b01 (previous ALU result).
- R3: When only the write-back-stage destination qualifies as a match, the select is 2'b10 (result from two instructions back).
- R4: When both older stages match the same source, the memory stage (one instruction back) wins and the select is 2'b01.
- R5: A source index of 0 never forwards; its select is always 2'b00.
- R6: A stage whose write enable is low never produces a match, even when its destination index equals the source.
- R7: Operand A and operand B are resolved independently. Each select depends only on its own source index, and 2'b11 never appears.
- R8: When execute holds a load with a nonzero destination and its write enable high, and either decode source equals that destination, stall_req and bubble_req are high in that same cycle (state RUN).
- R9: No stall is requested when execute is not a load, when its destination is 0, when its write enable is low, or when neither decode source matches.
- R10: A stall lasts exactly one cycle. In the cycle after a stall (state HOLD), stall_req and bubble_req are low even if the hazard inputs are unchanged.
- R11: While rst_n is low, stall_req and bubble_req are low, and the machine leaves reset in RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_src_a | input | REG_W | First source index of the instruction in decode |
| dec_src_b | input | REG_W | Second source index of the instruction in decode |
| exe_src_a | input | REG_W | First source index of the instruction in execute |
| exe_src_b | input | REG_W | Second source index of the instruction in execute |
| exe_dst | input | REG_W | Destination index of the instruction in execute |
| exe_wen | input | 1 | Register write enable of the instruction in execute |
| exe_load | input | 1 | Instruction in execute is a load |
| mem_dst | input | REG_W | Destination index of the instruction in the memory stage |
| mem_wen | input | 1 | Register write enable of the memory-stage instruction |
| wb_dst | input | REG_W | Destination index of the instruction in write-back |
| wb_wen | input | 1 | Register write enable of the write-back instruction |
| sel_a | output | 2 | Operand A source: 00 register file, 01 one back, 10 two back |
| sel_b | output | 2 | Operand B source, same encoding |
| stall_req | output | 1 | Hold PC and fetch/decode register this cycle |
| bubble_req | output | 1 | Insert a no-op into execute on the next edge |

## Verification
The forwarding selects are swept over every combination of source, memory destination and write-back destination in indices 0 to 3, with all four write-enable pairs. This covers the no-match, near-only, far-only and both-match cases, register 0, and disabled writers. Operand B is driven with a source that differs from operand A so that any crosstalk between the two operand paths shows. The load-use sweep runs over both decode sources, the execute destination, the load flag and the write enable. Each combination is held for two cycles, which separates a correct single-cycle stall in RUN from a missing stall or a stall that repeats in HOLD.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    // Operand source encoding seen by the execute-stage muxes
    typedef enum logic [1:0] {
        SRC_RF       = 2'b00,
        SRC_ONE_BACK = 2'b01,
        SRC_TWO_BACK = 2'b10
    } fwd_src_e;

    // Load-use stall controller states
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } stall_state_e;

endpackage

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
    import fwd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] near_dst,
    input  logic             near_wen,
    input  logic [REG_W-1:0] far_dst,
    input  logic             far_wen,
    output fwd_src_e         sel
);

    localparam logic [REG_W-1:0] ZERO_IDX = '0;

    logic src_live;
    logic near_hit;
    logic far_hit;

    always_comb begin
        src_live = (src != ZERO_IDX);
        near_hit = src_live && near_wen && (near_dst == src);
        far_hit  = src_live && far_wen  && (far_dst  == src);
    end

    // The younger producer holds the newer value, so it is tested first
    always_comb begin
        if (near_hit) begin
            sel = SRC_ONE_BACK;
        end else if (far_hit) begin
            sel = SRC_TWO_BACK;
        end else begin
            sel = SRC_RF;
        end
    end

endmodule

// File: rtl/fwd_loaduse_detect.sv
module fwd_loaduse_detect #(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC-1:0][REG_W-1:0] dec_src,
    input  logic [REG_W-1:0]              exe_dst,
    input  logic                          exe_wen,
    input  logic                          exe_load,
    output logic                          hazard
);

    localparam logic [REG_W-1:0] ZERO_IDX = '0;

    logic                load_live;
    logic [NUM_SRC-1:0]  src_hit;

    always_comb begin
        load_live = exe_load && exe_wen && (exe_dst != ZERO_IDX);
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        always_comb begin
            src_hit[s] = load_live && (dec_src[s] == exe_dst);
        end
    end

    always_comb begin
        hazard = |src_hit;
    end

endmodule

// File: rtl/fwd_stall_ctrl.sv
module fwd_stall_ctrl
    import fwd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hazard,
    output logic stall_req,
    output logic bubble_req
);

    stall_state_e state_q;
    stall_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: RUN->HOLD on hazard, HOLD->RUN always
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  state_d = hazard ? ST_HOLD : ST_RUN;
            ST_HOLD: state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        stall_req  = 1'b0;
        bubble_req = 1'b0;
        if (rst_n) begin
            unique case (state_q)
                ST_RUN: begin
                    stall_req  = hazard;
                    bubble_req = hazard;
                end
                ST_HOLD: begin
                    stall_req  = 1'b0;
                    bubble_req = 1'b0;
                end
                default: begin
                    stall_req  = 1'b0;
                    bubble_req = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
    import fwd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] dec_src_a,
    input  logic [REG_W-1:0] dec_src_b,
    input  logic [REG_W-1:0] exe_src_a,
    input  logic [REG_W-1:0] exe_src_b,
    input  logic [REG_W-1:0] exe_dst,
    input  logic             exe_wen,
    input  logic             exe_load,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             mem_wen,
    input  logic [REG_W-1:0] wb_dst,
    input  logic             wb_wen,
    output logic [1:0]       sel_a,
    output logic [1:0]       sel_b,
    output logic             stall_req,
    output logic             bubble_req
);

    localparam int NUM_SRC = 2;

    logic [NUM_SRC-1:0][REG_W-1:0] exe_src_vec;
    logic [NUM_SRC-1:0][REG_W-1:0] dec_src_vec;
    fwd_src_e                      sel_vec [NUM_SRC];
    logic                          lu_hazard;

    always_comb begin
        exe_src_vec[0] = exe_src_a;
        exe_src_vec[1] = exe_src_b;
        dec_src_vec[0] = dec_src_a;
        dec_src_vec[1] = dec_src_b;
    end

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_opnd
        fwd_operand_sel #(
            .REG_W (REG_W)
        ) u_sel (
            .src      (exe_src_vec[k]),
            .near_dst (mem_dst),
            .near_wen (mem_wen),
            .far_dst  (wb_dst),
            .far_wen  (wb_wen),
            .sel      (sel_vec[k])
        );
    end

    always_comb begin
        sel_a = sel_vec[0];
        sel_b = sel_vec[1];
    end

    fwd_loaduse_detect #(
        .REG_W   (REG_W),
        .NUM_SRC (NUM_SRC)
    ) u_lu (
        .dec_src  (dec_src_vec),
        .exe_dst  (exe_dst),
        .exe_wen  (exe_wen),
        .exe_load (exe_load),
        .hazard   (lu_hazard)
    );

    fwd_stall_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .hazard     (lu_hazard),
        .stall_req  (stall_req),
        .bubble_req (bubble_req)
    );

endmodule

// File: rtl/fwd_hazard_chk.sv
module fwd_hazard_chk #(
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] dec_src_a,
    input logic [REG_W-1:0] dec_src_b,
    input logic [REG_W-1:0] exe_src_a,
    input logic [REG_W-1:0] exe_src_b,
    input logic [REG_W-1:0] exe_dst,
    input logic             exe_wen,
    input logic             exe_load,
    input logic [REG_W-1:0] mem_dst,
    input logic             mem_wen,
    input logic [REG_W-1:0] wb_dst,
    input logic             wb_wen,
    input logic [1:0]       sel_a,
    input logic [1:0]       sel_b,
    input logic             stall_req,
    input logic             bubble_req
);

    // R4
    prio_near_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wen && (exe_src_a != '0) && (mem_dst == exe_src_a)) |-> (sel_a == 2'b01));

    // R5
    zero_src_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_src_b == '0) |-> (sel_b == 2'b00));

    // R6
    no_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wen && !wb_wen) |-> ((sel_a == 2'b00) && (sel_b == 2'b00)));

    // R7
    sel_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a != 2'b11) && (sel_b != 2'b11));

    // R8
    loaduse_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_load && exe_wen && (exe_dst != '0) &&
         ((dec_src_a == exe_dst) || (dec_src_b == exe_dst)))
        |-> (stall_req || $past(stall_req)));

    // R9
    no_load_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!exe_load || !exe_wen) |-> !stall_req);

    // R10
    stall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |=> (!stall_req && !bubble_req));

endmodule

bind fwd_hazard_unit fwd_hazard_chk #(.REG_W(REG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_src_a  (dec_src_a),
    .dec_src_b  (dec_src_b),
    .exe_src_a  (exe_src_a),
    .exe_src_b  (exe_src_b),
    .exe_dst    (exe_dst),
    .exe_wen    (exe_wen),
    .exe_load   (exe_load),
    .mem_dst    (mem_dst),
    .mem_wen    (mem_wen),
    .wb_dst     (wb_dst),
    .wb_wen     (wb_wen),
    .sel_a      (sel_a),
    .sel_b      (sel_b),
    .stall_req  (stall_req),
    .bubble_req (bubble_req)
);

// File: tb/sim_fwd_hazard_unit.sv
`timescale 1ns/1ps
module sim_fwd_hazard_unit;

    localparam int RW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [RW-1:0] dec_src_a = '0, dec_src_b = '0;
    logic [RW-1:0] exe_src_a = '0, exe_src_b = '0, exe_dst = '0;
    logic          exe_wen = 1'b0, exe_load = 1'b0;
    logic [RW-1:0] mem_dst = '0, wb_dst = '0;
    logic          mem_wen = 1'b0, wb_wen = 1'b0;
    logic [1:0]    sel_a, sel_b;
    logic          stall_req, bubble_req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    fwd_hazard_unit #(.REG_W(RW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
        .exe_src_a(exe_src_a), .exe_src_b(exe_src_b),
        .exe_dst(exe_dst), .exe_wen(exe_wen), .exe_load(exe_load),
        .mem_dst(mem_dst), .mem_wen(mem_wen),
        .wb_dst(wb_dst), .wb_wen(wb_wen),
        .sel_a(sel_a), .sel_b(sel_b),
        .stall_req(stall_req), .bubble_req(bubble_req)
    );

    function automatic logic [1:0] exp_sel(int src, int md, int mw, int wd, int ww);
        if (src != 0 && mw != 0 && md == src) return 2'b01;
        if (src != 0 && ww != 0 && wd == src) return 2'b10;
        return 2'b00;
    endfunction

    function automatic string sel_tag(int src, int md, int mw, int wd, int ww);
        if (src == 0) return "R5";
        if (mw != 0 && ww != 0 && md == src && wd == src) return "R4";
        if (mw != 0 && md == src) return "R2";
        if (ww != 0 && wd == src) return "R3";
        if (md == src || wd == src) return "R6";
        return "R1";
    endfunction

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        // R11: reset holds the stall low even with a live hazard
        exe_load = 1'b1; exe_wen = 1'b1; exe_dst = 5'd3; dec_src_a = 5'd3;
        @(negedge clk); #2;
        check("R11 reset stall", {2'b00, bubble_req, stall_req}, 4'b0000);
        exe_load = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        check("R11 post-reset idle", {2'b00, bubble_req, stall_req}, 4'b0000);

        // Forwarding sweep: R1..R7
        for (int sa = 0; sa < 4; sa++)
            for (int md = 0; md < 4; md++)
                for (int wd = 0; wd < 4; wd++)
                    for (int mw = 0; mw < 2; mw++)
                        for (int ww = 0; ww < 2; ww++) begin
                            @(negedge clk);
                            exe_src_a = RW'(sa);
                            exe_src_b = RW'(3 - sa);
                            mem_dst = RW'(md); mem_wen = mw[0];
                            wb_dst  = RW'(wd); wb_wen  = ww[0];
                            #2;
                            check(sel_tag(sa, md, mw, wd, ww), {2'b00, sel_a},
                                  {2'b00, exp_sel(sa, md, mw, wd, ww)});
                            check("R7 operand b", {2'b00, sel_b},
                                  {2'b00, exp_sel(3 - sa, md, mw, wd, ww)});
                        end

        // Load-use sweep: R8, R9, R10
        for (int da = 0; da < 4; da++)
            for (int db = 0; db < 4; db++)
                for (int ed = 0; ed < 4; ed++)
                    for (int ld = 0; ld < 2; ld++)
                        for (int we = 0; we < 2; we++) begin
                            logic e;
                            e = (ld != 0) && (we != 0) && (ed != 0) &&
                                (da == ed || db == ed);
                            @(negedge clk);
                            dec_src_a = RW'(da); dec_src_b = RW'(db);
                            exe_dst = RW'(ed); exe_load = ld[0]; exe_wen = we[0];
                            #2;
                            check(e ? "R8 stall" : "R9 no stall",
                                  {2'b00, bubble_req, stall_req}, {2'b00, e, e});
                            @(negedge clk); #2;
                            check("R10 second cycle",
                                  {2'b00, bubble_req, stall_req},
                                  e ? 4'b0000 : 4'b0000);
                        end

        // R10: back-to-back hazard returns to stalling after HOLD
        @(negedge clk);
        dec_src_a = 5'd2; dec_src_b = 5'd0; exe_dst = 5'd2;
        exe_load = 1'b1; exe_wen = 1'b1;
        #2;
        check("R10 run stall", {2'b00, bubble_req, stall_req}, 4'b0011);
        @(negedge clk); #2;
        check("R10 hold", {2'b00, bubble_req, stall_req}, 4'b0000);
        @(negedge clk); #2;
        check("R10 run again", {2'b00, bubble_req, stall_req}, 4'b0011);
        @(negedge clk);
        exe_load = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule